// File: doc/BRIEF.md
# SIMD Lane Shuffle Network

This block reorders the lanes of a wide SIMD vector between two vector operations. The vector holds 32 lanes of 16 bits, 512 bits in all. Each pass applies one of three fixed patterns. The first is a perfect shuffle (the two halves are interleaved) followed by an optional swap of adjacent lane pairs. The second is the optional pair swap followed by the inverse perfect shuffle. The third is the pair swap alone. A 16-bit exchange mask selects which adjacent pairs are swapped.

The result of one pass is written to a register. That register can be fed back as the input of the next pass, one pass per clock. In this way a permutation built from several passes, such as an FFT butterfly reordering or a transpose, comes out of a single request. The caller pulses `start` together with the vector, the mode, the mask and a pass count from 1 to 5. When the last pass has been applied, the caller reads the result and `done` goes high.

Top module: `lane_shuffle_net`

## Requirements
- R1: In mode 0 (exchange-only), a set bit k of `xmask` swaps lanes 2k and 2k+1, where lane n occupies bits [16n+15:16n]. A clear bit k leaves lanes 2k and 2k+1 where they are. No other reordering happens.
- R2: In mode 1 (shuffle-exchange), one pass moves lane i to lane (2i mod 31) for i<31 and keeps lane 31 in place. It then applies the R1 pair swap.
- R3: In mode 2 (inverse shuffle-exchange), one pass first applies the R1 pair swap. It then moves lane (2i mod 31) to lane i for i<31 and keeps lane 31 in place.
- R4: Mode 3 gives the same result as mode 0.
- R5: A request samples `start`. With a pass count N from 1 to 5, `vec_out` shows the result of N passes at the Nth rising edge, counting the edge that sampled `start` as the first. `done` rises at that same edge and stays low before it.
- R6: A pass count of 0 runs one pass, and a pass count above 5 runs five passes.
- R7: Five shuffle-exchange passes with an all-zero mask return the original lane order.
- R8: While `rst_n` is low at a rising edge, `done` and `vec_out` clear to zero at that edge.
- R9: Mode, mask and vector are taken only at `start`. Changes to them later do not affect the running request. Once `done` is high, `vec_out` and `done` hold until the next `start`.
- R10: A `start` during a running request abandons that request and begins the new one, with timing per R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request pulse; samples the operands below |
| mode | input | 2 | 0 exchange-only, 1 shuffle-exchange, 2 inverse shuffle-exchange, 3 as 0 |
| xmask | input | 16 | Bit k enables the swap of lanes 2k and 2k+1 |
| pass_cnt | input | 3 | Number of passes, 1 to 5 (0 and above 5 are clamped) |
| vec_in | input | 512 | Source vector, 32 lanes of 16 bits |
| vec_out | output | 512 | Permuted vector after the last pass |
| done | output | 1 | High once the requested passes are complete |

## Verification
The hardest state to reach from the ports is a request that is still in flight in the feedback loop. The operands are then held internally, and intermediate vectors are visible at the output. The bench starts five-pass requests and then changes `vec_in`, `mode` and `xmask` mid-run to show that the held operands are unaffected. It also pulses `start` again two passes into a run to show that the new request replaces the old one. Each lane gets a distinct value, so any misrouted lane shows up in the compared vector.

// File: rtl/shuf_pkg.sv
// Package for the lane shuffle network.
// Holds the default geometry and the pass pattern codes.
// Assumes the lane count is a power of two.
package shuf_pkg;
    localparam int DEF_LANES  = 32;
    localparam int DEF_LANE_W = 16;

    typedef enum logic [1:0] {
        SH_XCHG = 2'b00,
        SH_SHUF = 2'b01,
        SH_INV  = 2'b10,
        SH_ALT  = 2'b11
    } shuf_mode_e;
endpackage

// File: rtl/shuf_stage.sv
// One combinational pass of the shuffle network.
// Two layers form the pass. The pre layer is a shuffle, a pair swap or a straight path.
// The post layer is a pair swap, an inverse shuffle or a straight path.
// The mode selects which combination is used.
// Assumes LANES is a power of two and mask bit k governs lanes 2k and 2k+1.
module shuf_stage
    import shuf_pkg::*;
#(
    parameter int LANES  = DEF_LANES,
    parameter int LANE_W = DEF_LANE_W,
    localparam int IDX_W = $clog2(LANES),
    localparam int PAIRS = LANES / 2
) (
    input  logic [LANES-1:0][LANE_W-1:0] in_v,
    input  shuf_mode_e                   mode,
    input  logic [PAIRS-1:0]             mask,
    output logic [LANES-1:0][LANE_W-1:0] out_v
);
    logic [LANES-1:0][LANE_W-1:0] shuf_in, swap_in, pre_v;
    logic [LANES-1:0][LANE_W-1:0] swap_pre, ishuf_pre;

    // Fixed wiring for each lane: perfect shuffle (source = rotate-right of index),
    // inverse shuffle (source = rotate-left of index), and conditional pair swap.
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        localparam int SRC_SH  = (j >> 1) | ((j & 1) << (IDX_W - 1));
        localparam int SRC_INV = ((j << 1) & (LANES - 1)) | (j >> (IDX_W - 1));
        localparam int MATE    = j ^ 1;
        assign shuf_in[j]   = in_v[SRC_SH];
        assign swap_in[j]   = mask[j/2] ? in_v[MATE] : in_v[j];
        assign swap_pre[j]  = mask[j/2] ? pre_v[MATE] : pre_v[j];
        assign ishuf_pre[j] = pre_v[SRC_INV];
    end

    // Choose the first layer: shuffle, pair swap, or straight through.
    always_comb begin
        unique case (mode)
            SH_SHUF: pre_v = shuf_in;
            SH_INV:  pre_v = swap_in;
            default: pre_v = in_v;
        endcase
    end

    // Choose the second layer: inverse shuffle after a swap, otherwise pair swap.
    always_comb begin
        out_v = (mode == SH_INV) ? ishuf_pre : swap_pre;
    end

    // With no pair enabled, exchange-only mode must pass the vector unchanged.
    always_comb begin
        if (!$isunknown({in_v, mode, mask}) && (mode == SH_XCHG) && (mask == '0)) begin
            assert_xchg_idle_R1: assert (out_v == in_v);
        end
    end
endmodule

// File: rtl/shuf_ctrl.sv
// Pass sequencer for the shuffle network.
// It clamps the requested pass count, counts the feedback passes and raises done.
// Assumes start may arrive at any cycle and always restarts the count.
module shuf_ctrl #(
    parameter int MAX_PASS = 5,
    parameter int CNT_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] pass_cnt,
    output logic             step,
    output logic             done
);
    logic [CNT_W-1:0] rem_q;
    logic             busy_q;
    logic             done_q;
    logic [CNT_W-1:0] eff_cnt;

    // Clamp the pass count into the range 1..MAX_PASS.
    always_comb begin
        if (pass_cnt == '0)
            eff_cnt = CNT_W'(1);
        else if (pass_cnt > CNT_W'(MAX_PASS))
            eff_cnt = CNT_W'(MAX_PASS);
        else
            eff_cnt = pass_cnt;
    end

    // Track the passes still to run after the current one, plus busy and done flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else if (start) begin
            rem_q  <= eff_cnt - CNT_W'(1);
            busy_q <= (eff_cnt > CNT_W'(1));
            done_q <= (eff_cnt == CNT_W'(1));
        end else if (busy_q) begin
            rem_q <= rem_q - CNT_W'(1);
            if (rem_q == CNT_W'(1)) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end
        end
    end

    assign step = start | busy_q;
    assign done = done_q;

    // Every busy cycle without a restart consumes exactly one pass.
    assert_one_pass_per_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !start) |=> (rem_q == $past(rem_q) - CNT_W'(1)));

    // After a request, no more than MAX_PASS-1 passes remain.
    assert_pass_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (rem_q < CNT_W'(MAX_PASS)));

    // A single-pass request completes at the sampling edge.
    assert_single_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && pass_cnt <= CNT_W'(1)) |=> done_q);

    // A multi-pass request clears done at the sampling edge.
    assert_multi_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && pass_cnt > CNT_W'(1)) |=> !done_q);
endmodule

// File: rtl/lane_shuffle_net.sv
// SIMD lane shuffle network, top level.
// It holds the vector register and the operands latched at start. It feeds the register
// back through one pass stage per clock until the sequencer reports done.
// Assumes LANES is a power of two; the pass limit equals log2(LANES).
module lane_shuffle_net
    import shuf_pkg::*;
#(
    parameter int LANES  = DEF_LANES,
    parameter int LANE_W = DEF_LANE_W,
    localparam int IDX_W = $clog2(LANES),
    localparam int PAIRS = LANES / 2,
    localparam int CNT_W = $clog2(IDX_W + 1),
    localparam int VEC_W = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       mode,
    input  logic [PAIRS-1:0] xmask,
    input  logic [CNT_W-1:0] pass_cnt,
    input  logic [VEC_W-1:0] vec_in,
    output logic [VEC_W-1:0] vec_out,
    output logic             done
);
    logic [LANES-1:0][LANE_W-1:0] data_q, src_v, nxt_v;
    shuf_mode_e                   mode_q, mode_sel;
    logic [PAIRS-1:0]             mask_q, mask_sel;
    logic                         step;

    // Pick operands: fresh ones on start, held ones while feeding back.
    always_comb begin
        src_v    = start ? vec_in : data_q;
        mode_sel = start ? shuf_mode_e'(mode) : mode_q;
        mask_sel = start ? xmask : mask_q;
    end

    shuf_stage #(.LANES(LANES), .LANE_W(LANE_W)) u_stage (
        .in_v  (src_v),
        .mode  (mode_sel),
        .mask  (mask_sel),
        .out_v (nxt_v)
    );

    shuf_ctrl #(.MAX_PASS(IDX_W), .CNT_W(CNT_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .pass_cnt (pass_cnt),
        .step     (step),
        .done     (done)
    );

    // Update the vector register on each pass and latch the operands on start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            mode_q <= SH_XCHG;
            mask_q <= '0;
        end else begin
            if (step)
                data_q <= nxt_v;
            if (start) begin
                mode_q <= shuf_mode_e'(mode);
                mask_q <= xmask;
            end
        end
    end

    assign vec_out = data_q;

    // Reset clears the result and the completion flag.
    assert_reset_clear_R8: assert property (@(posedge clk)
        !rst_n |=> (!done && vec_out == '0));

    // A finished result holds until the next request.
    assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(vec_out)));
endmodule

// File: tb/lane_shuffle_net_bench.sv
// Bench for the lane shuffle network: a vector table walked by one loop, then directed cases.
module lane_shuffle_net_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NL   = 32;
    localparam int NV   = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         start;
    logic [1:0]   mode;
    logic [15:0]  xmask;
    logic [2:0]   pass_cnt;
    logic [511:0] vec_in;
    logic [511:0] vec_out;
    logic         done;

    int n_checks = 0;
    int n_fail   = 0;

    localparam int T_MODE[NV] = '{0, 0, 1, 2, 3, 1, 2, 1};
    localparam int T_MASK[NV] = '{32'h0000, 32'hA5C3, 32'hFFFF, 32'h1234,
                                  32'h8001, 32'h0F0F, 32'h0000, 32'h5555};
    localparam int T_PASS[NV] = '{1, 1, 1, 1, 2, 3, 4, 5};
    localparam int T_SEED[NV] = '{3, 17, 41, 99, 7, 250, 12, 61};
    localparam string T_TAG[NV] = '{"R1", "R1", "R2", "R3", "R4", "R5", "R3", "R5"};

    lane_shuffle_net u_lane_shuffle_net (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .mode     (mode),
        .xmask    (xmask),
        .pass_cnt (pass_cnt),
        .vec_in   (vec_in),
        .vec_out  (vec_out),
        .done     (done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Distinct value in every lane so misrouting is visible.
    function automatic logic [511:0] mkvec(input int seed);
        logic [511:0] v;
        for (int i = 0; i < NL; i++) v[16*i +: 16] = 16'(seed * 257 + i * 4099 + 1);
        return v;
    endfunction

    // Destination of lane i under the perfect shuffle.
    function automatic int shuf_dst(input int i);
        return (i == NL - 1) ? i : (2 * i) % (NL - 1);
    endfunction

    function automatic logic [511:0] swap_pairs(input logic [511:0] v, input logic [15:0] m);
        logic [511:0] r = v;
        for (int k = 0; k < 16; k++)
            if (m[k]) begin
                r[16*(2*k) +: 16]   = v[16*(2*k+1) +: 16];
                r[16*(2*k+1) +: 16] = v[16*(2*k) +: 16];
            end
        return r;
    endfunction

    function automatic logic [511:0] one_pass(input logic [511:0] v, input int md, input logic [15:0] m);
        logic [511:0] t;
        if (md == 1) begin
            for (int i = 0; i < NL; i++) t[16*shuf_dst(i) +: 16] = v[16*i +: 16];
            return swap_pairs(t, m);
        end else if (md == 2) begin
            logic [511:0] s = swap_pairs(v, m);
            for (int i = 0; i < NL; i++) t[16*i +: 16] = s[16*shuf_dst(i) +: 16];
            return t;
        end
        return swap_pairs(v, m);
    endfunction

    function automatic logic [511:0] model(input logic [511:0] v, input int md, input logic [15:0] m, input int n);
        logic [511:0] r = v;
        int eff = (n == 0) ? 1 : (n > 5 ? 5 : n);
        for (int p = 0; p < eff; p++) r = one_pass(r, md, m);
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive a request at the falling edge; return just after the sampling edge.
    task automatic launch(input int md, input logic [15:0] m, input int n, input logic [511:0] v);
        @(negedge clk);
        start = 1'b1; mode = 2'(md); xmask = m; pass_cnt = 3'(n); vec_in = v;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_edges(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [511:0] v, e;
        rst_n = 1'b0; start = 1'b0; mode = '0; xmask = '0; pass_cnt = 3'd1; vec_in = '0;
        wait_edges(3);
        // R8: reset state
        check(done == 1'b0, "R8 done", 512'(done), 512'd0);
        check(vec_out == '0, "R8 vec_out", vec_out, '0);
        rst_n = 1'b1;
        wait_edges(1);

        // Table walk: R1..R5
        for (int t = 0; t < NV; t++) begin
            v = mkvec(T_SEED[t]);
            e = model(v, T_MODE[t], 16'(T_MASK[t]), T_PASS[t]);
            launch(T_MODE[t], 16'(T_MASK[t]), T_PASS[t], v);
            if (T_PASS[t] > 1) begin
                wait_edges(T_PASS[t] - 2);
                check(done == 1'b0, {T_TAG[t], " done early"}, 512'(done), 512'd0);
                wait_edges(1);
            end
            check(done == 1'b1, {T_TAG[t], " done"}, 512'(done), 512'd1);
            check(vec_out == e, {T_TAG[t], " vector"}, vec_out, e);
        end

        // R7: five shuffle passes with no exchange give identity
        v = mkvec(77);
        launch(1, 16'h0000, 5, v);
        wait_edges(4);
        check(done && vec_out == v, "R7 identity", vec_out, v);

        // R4: mode 3 equals mode 0
        v = mkvec(5);
        e = model(v, 0, 16'hF0F0, 1);
        launch(3, 16'hF0F0, 1, v);
        check(vec_out == e, "R4 alt mode", vec_out, e);

        // R6: pass count 0 runs one pass
        v = mkvec(31);
        e = model(v, 1, 16'h3C3C, 1);
        launch(1, 16'h3C3C, 0, v);
        check(done == 1'b1, "R6 zero count done", 512'(done), 512'd1);
        check(vec_out == e, "R6 zero count vector", vec_out, e);

        // R6: pass count 7 runs five passes
        v = mkvec(44);
        e = model(v, 2, 16'h00FF, 5);
        launch(2, 16'h00FF, 7, v);
        wait_edges(3);
        check(done == 1'b0, "R6 clamp not early", 512'(done), 512'd0);
        wait_edges(1);
        check(done == 1'b1 && vec_out == e, "R6 clamp vector", vec_out, e);

        // R9: operand changes mid-run are ignored; result holds after done
        v = mkvec(123);
        e = model(v, 1, 16'h9669, 4);
        launch(1, 16'h9669, 4, v);
        mode = 2'd2; xmask = 16'hFFFF; vec_in = mkvec(9); pass_cnt = 3'd1;
        wait_edges(3);
        check(done == 1'b1 && vec_out == e, "R9 operands held", vec_out, e);
        wait_edges(4);
        check(done == 1'b1 && vec_out == e, "R9 result holds", vec_out, e);

        // R10: restart during a running request
        v = mkvec(200);
        launch(1, 16'hAAAA, 5, v);
        wait_edges(1);
        v = mkvec(201);
        e = model(v, 0, 16'h0F0F, 1);
        launch(0, 16'h0F0F, 1, v);
        check(done == 1'b1 && vec_out == e, "R10 restart", vec_out, e);
        wait_edges(5);
        check(done == 1'b1 && vec_out == e, "R10 old request gone", vec_out, e);

        // R8: reset after activity clears outputs
        rst_n = 1'b0;
        wait_edges(1);
        check(done == 1'b0 && vec_out == '0, "R8 reset again", vec_out, '0);
        rst_n = 1'b1;

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule